// File: doc/BRIEF.md
# Header Store with Single-Error Correction, Double-Error Detection and Forced Faults

The block is a synchronous RAM for packet-header words. Each logical word is 256 bits wide: bits 207:0 carry the header, and bits 255:208 form the code field. On a write the block computes an extended Hamming code over the 208 header bits. Eight check bits go to bits 215:208 and an overall parity bit goes to bit 216. Code-field bits 255:217 are constant zero, so they are not kept in storage. On a read the stored word is decoded. A single flipped bit is repaired. Two flipped bits are flagged and the data is returned as stored. Each erroneous read records the row and the failing bit position and fires a one-cycle interrupt pulse.

Requests use one valid/ready channel that carries both reads and writes. A read response comes back on a valid/ready channel. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. While a response is held with `resp_ready` low, no new request is accepted, and the held response does not change.

A fault-injection path tests the code. A one-cycle `inj_arm` strobe captures a target row, one bit index (single fault) or two (double fault), and the fault type. The next accepted write to that row stores the word with those bits inverted, and the arming then clears. The inversion is suppressed when `crc_mode` is 1, or when both error enables are low. Header bits 207:200 have no functional meaning, which makes them a safe target for forced double faults.

Top module: `hdr_ecc_ram`

## Requirements
- R1: A read request accepted at clock edge N presents `resp_valid`=1 after edge N. The response carries the 208 bits last written to that row, with `resp_sec`=0, `resp_ded`=0 and no `err_irq`, unless a fault was injected.
- R2: While `resp_valid`=1 and `resp_ready`=0, `req_ready` is 0 and `resp_data`, `resp_sec` and `resp_ded` stay unchanged. Asserting `resp_ready` drops `resp_valid` at the next edge.
- R3: A forced single fault at header bit i (0..207) is repaired on read. The read returns the original data with `resp_sec`=1, `stat_bit`=i and `stat_row` = the row.
- R4: A forced double fault at two distinct header bits returns `resp_ded`=1 and `resp_sec`=0. The data comes back with both bits still inverted, and `stat_bit` is 0.
- R5: A forced single fault in the stored code bits 216:208 is repaired. The read returns `resp_sec`=1, unchanged data, and `stat_bit`=0.
- R6: With `crc_mode`=1 at the time of the matching write, no bit is inverted. The arming is still consumed by that write.
- R7: With both `rx_err_en` and `tx_err_en` low at the matching write, no bit is inverted. Either enable alone is enough to permit the fault.
- R8: An armed fault affects only the next write to its row. Writes to other rows are untouched, and a second write to the row is clean.
- R9: `err_irq` is high for exactly one cycle per erroneous read (SEC or DED). The pulse coincides with the first cycle of that response, even when the response is stalled.
- R10: A fault index in 217..255 (constant-zero code bits) has no effect on stored data or on the decode.
- R11: After reset, `resp_valid`=0, `err_irq`=0, `stat_row`=0, `stat_bit`=0 and `req_ready`=1.
- R12: `stat_row` and `stat_bit` keep their values across error-free reads until the next erroneous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W (4) | Row address |
| req_data | input | 208 | Header data for writes |
| resp_valid | output | 1 | Read response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_data | output | 208 | Corrected (or raw on DED) header |
| resp_sec | output | 1 | Single error corrected |
| resp_ded | output | 1 | Double error detected |
| inj_arm | input | 1 | Strobe capturing the fault settings |
| inj_row | input | ROW_W (4) | Row that receives the fault |
| inj_double | input | 1 | 1 = invert two bits, 0 = one bit |
| inj_bit_a | input | 16 | Word bit inverted for single or double fault |
| inj_bit_b | input | 16 | Second bit inverted for a double fault |
| crc_mode | input | 1 | 1 suppresses all fault inversion |
| rx_err_en | input | 1 | Fault enable, receive side |
| tx_err_en | input | 1 | Fault enable, transmit side |
| err_irq | output | 1 | One-cycle pulse on an erroneous read |
| stat_row | output | ROW_W (4) | Row of the last erroneous read |
| stat_bit | output | 16 | Bit index of the last erroneous read |

## Verification
A read accepted at one edge has its response fields, `err_irq` and the status outputs all updated by that same edge. The bench therefore samples them at the following falling edge, and it samples `err_irq` again one cycle later to confirm that it has dropped. Writes land in storage at their accepting edge, so a read issued in the next cycle already observes the stored, possibly faulted, word. Arming takes one edge, and gate inputs are held stable over the write's accepting edge. Stall checks hold `resp_ready` low across two further edges and compare the held response and `req_ready` at each falling edge.

// File: rtl/hdr_ecc_pkg.sv
package hdr_ecc_pkg;
  localparam int DATA_W  = 208;
  localparam int HAM_W   = 8;
  localparam int STORE_W = DATA_W + HAM_W + 1;  // parity at bit 216
  localparam int IDX_W   = 16;

  // Codeword position of header bit i: the (i+1)-th non-power-of-two from 3.
  function automatic int data_pos(int i);
    int n;
    int res;
    n   = 0;
    res = 0;
    for (int q = 3; q < 512; q++) begin
      if (((q & (q - 1)) != 0) && (res == 0)) begin
        if (n == i) res = q;
        n++;
      end
    end
    return res;
  endfunction

  // Header bits covered by Hamming check bit j.
  function automatic logic [DATA_W-1:0] cover_mask(int j);
    logic [DATA_W-1:0] m;
    int i;
    m = '0;
    i = 0;
    for (int q = 3; q < 512; q++) begin
      if (((q & (q - 1)) != 0) && (i < DATA_W)) begin
        m[i] = q[j];
        i++;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/hdr_ecc_enc.sv
module hdr_ecc_enc
  import hdr_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [HAM_W-1:0]  check
);
  for (genvar j = 0; j < HAM_W; j++) begin : g_chk
    localparam logic [DATA_W-1:0] MASK = cover_mask(j);
    assign check[j] = ^(data & MASK);
  end
endmodule

// File: rtl/hdr_ecc_dec.sv
module hdr_ecc_dec
  import hdr_ecc_pkg::*;
(
  input  logic [STORE_W-1:0] word,
  output logic [DATA_W-1:0]  data_out,
  output logic               sec,
  output logic               ded,
  output logic [IDX_W-1:0]   bit_idx
);
  logic [DATA_W-1:0] raw;
  logic [HAM_W-1:0]  stored_chk;
  logic [HAM_W-1:0]  calc_chk;
  logic [HAM_W-1:0]  syn;
  logic              ovr;
  logic [DATA_W-1:0] hit;
  logic              data_hit;
  logic              code_hit;

  assign raw        = word[DATA_W-1:0];
  assign stored_chk = word[DATA_W +: HAM_W];

  hdr_ecc_enc u_recalc (.data(raw), .check(calc_chk));

  assign syn = stored_chk ^ calc_chk;
  assign ovr = ^word;

  for (genvar i = 0; i < DATA_W; i++) begin : g_hit
    localparam int POS = data_pos(i);
    assign hit[i] = (syn == HAM_W'(POS));
  end

  assign data_hit = |hit;
  // syndrome zero: parity bit flipped; one-hot: a check bit flipped
  assign code_hit = (syn == '0) || ((syn & (syn - 1'b1)) == '0);

  assign sec = ovr && (data_hit || code_hit);
  assign ded = (!ovr && (syn != '0)) || (ovr && !data_hit && !code_hit);

  assign data_out = sec ? (raw ^ hit) : raw;

  always_comb begin
    bit_idx = '0;
    if (sec) begin
      for (int i = 0; i < DATA_W; i++) begin
        if (hit[i]) bit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/hdr_ecc_inject.sv
module hdr_ecc_inject
  import hdr_ecc_pkg::*;
#(
  parameter int ROW_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [ROW_W-1:0]   arm_row,
  input  logic               arm_double,
  input  logic [IDX_W-1:0]   arm_a,
  input  logic [IDX_W-1:0]   arm_b,
  input  logic               crc_mode,
  input  logic               rx_en,
  input  logic               tx_en,
  input  logic               wr_fire,
  input  logic [ROW_W-1:0]   wr_row,
  output logic [STORE_W-1:0] flip_mask
);
  logic             armed_q;
  logic [ROW_W-1:0] row_q;
  logic             dbl_q;
  logic [IDX_W-1:0] a_q;
  logic [IDX_W-1:0] b_q;
  logic             hit;
  logic             allow;

  assign hit   = armed_q && wr_fire && (wr_row == row_q);
  assign allow = !crc_mode && (rx_en || tx_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      row_q   <= '0;
      dbl_q   <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
    end else if (arm) begin
      armed_q <= 1'b1;
      row_q   <= arm_row;
      dbl_q   <= arm_double;
      a_q     <= arm_a;
      b_q     <= arm_b;
    end else if (hit) begin
      armed_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < STORE_W; k++) begin : g_mask
    assign flip_mask[k] = hit && allow &&
                          ((a_q == IDX_W'(k)) || (dbl_q && (b_q == IDX_W'(k))));
  end

  AST_ARM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !arm) |=> !armed_q); // R8
endmodule

// File: rtl/hdr_ecc_ram.sv
module hdr_ecc_ram
  import hdr_ecc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ROW_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [DATA_W-1:0] req_data,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_data,
  output logic              resp_sec,
  output logic              resp_ded,
  input  logic              inj_arm,
  input  logic [ROW_W-1:0]  inj_row,
  input  logic              inj_double,
  input  logic [IDX_W-1:0]  inj_bit_a,
  input  logic [IDX_W-1:0]  inj_bit_b,
  input  logic              crc_mode,
  input  logic              rx_err_en,
  input  logic              tx_err_en,
  output logic              err_irq,
  output logic [ROW_W-1:0]  stat_row,
  output logic [IDX_W-1:0]  stat_bit
);
  logic [STORE_W-1:0] mem [DEPTH];
  logic               accept;
  logic               wr_fire;
  logic               rd_fire;
  logic [HAM_W-1:0]   wr_chk;
  logic [STORE_W-1:0] wr_word;
  logic [STORE_W-1:0] flip_mask;
  logic [STORE_W-1:0] rd_word;
  logic [DATA_W-1:0]  dec_data;
  logic               dec_sec;
  logic               dec_ded;
  logic [IDX_W-1:0]   dec_idx;

  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_fire   = accept && req_write;
  assign rd_fire   = accept && !req_write;

  hdr_ecc_enc u_enc (.data(req_data), .check(wr_chk));

  hdr_ecc_inject #(.ROW_W(ROW_W)) u_inject (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (inj_arm),
    .arm_row    (inj_row),
    .arm_double (inj_double),
    .arm_a      (inj_bit_a),
    .arm_b      (inj_bit_b),
    .crc_mode   (crc_mode),
    .rx_en      (rx_err_en),
    .tx_en      (tx_err_en),
    .wr_fire    (wr_fire),
    .wr_row     (req_row),
    .flip_mask  (flip_mask)
  );

  assign wr_word = {(^req_data) ^ (^wr_chk), wr_chk, req_data} ^ flip_mask;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[req_row] <= wr_word;
  end

  assign rd_word = mem[req_row];

  hdr_ecc_dec u_dec (
    .word     (rd_word),
    .data_out (dec_data),
    .sec      (dec_sec),
    .ded      (dec_ded),
    .bit_idx  (dec_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
      resp_sec   <= 1'b0;
      resp_ded   <= 1'b0;
      err_irq    <= 1'b0;
      stat_row   <= '0;
      stat_bit   <= '0;
    end else begin
      err_irq <= rd_fire && (dec_sec || dec_ded);
      if (rd_fire) begin
        resp_valid <= 1'b1;
        resp_data  <= dec_data;
        resp_sec   <= dec_sec;
        resp_ded   <= dec_ded;
        if (dec_sec || dec_ded) begin
          stat_row <= req_row;
          stat_bit <= dec_idx;
        end
      end else if (resp_ready) begin
        resp_valid <= 1'b0;
      end
    end
  end

  AST_IRQ_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (resp_valid && (resp_sec || resp_ded))); // R9
  AST_SEC_DED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !(resp_sec && resp_ded)); // R4
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data) && $stable(resp_sec))); // R2
  AST_STAT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (stat_row == $past(req_row))); // R3
endmodule

// File: tb/hdr_ecc_ram_bench.sv
`timescale 1ns/1ps
module hdr_ecc_ram_bench;
  localparam int DW = 208;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [3:0]    req_row = '0;
  logic [DW-1:0] req_data = '0;
  logic          resp_valid;
  logic          resp_ready = 1'b1;
  logic [DW-1:0] resp_data;
  logic          resp_sec;
  logic          resp_ded;
  logic          inj_arm = 1'b0;
  logic [3:0]    inj_row = '0;
  logic          inj_double = 1'b0;
  logic [15:0]   inj_bit_a = '0;
  logic [15:0]   inj_bit_b = '0;
  logic          crc_mode = 1'b0;
  logic          rx_err_en = 1'b0;
  logic          tx_err_en = 1'b0;
  logic          err_irq;
  logic [3:0]    stat_row;
  logic [15:0]   stat_bit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hdr_ecc_ram u_hdr_ecc_ram (.*);

  function automatic logic [DW-1:0] pat(int s);
    logic [223:0] t;
    for (int k = 0; k < 7; k++)
      t[k*32 +: 32] = 32'(s) * 32'h9E3779B9 + 32'(k) * 32'h7F4A7C15 + 32'h1234;
    return t[DW-1:0];
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [3:0] row, logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_row = row; req_data = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic arm(logic [3:0] row, logic dbl, int a, int b);
    @(negedge clk);
    inj_arm = 1'b1; inj_row = row; inj_double = dbl;
    inj_bit_a = 16'(a); inj_bit_b = 16'(b);
    @(negedge clk);
    inj_arm = 1'b0;
  endtask

  // issue read; leaves sampling point at negedge after accept
  task automatic start_read(logic [3:0] row);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_row = row;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic read_expect(string req, logic [3:0] row, logic [DW-1:0] exp,
                             logic e_sec, logic e_ded);
    start_read(row);
    chk(resp_valid === 1'b1, {req, " valid"}, DW'(resp_valid), 1);
    chk(resp_data === exp, {req, " data"}, resp_data, exp);
    chk(resp_sec === e_sec, {req, " sec"}, DW'(resp_sec), DW'(e_sec));
    chk(resp_ded === e_ded, {req, " ded"}, DW'(resp_ded), DW'(e_ded));
    chk(err_irq === (e_sec | e_ded), {req, " irq"}, DW'(err_irq), DW'(e_sec | e_ded));
    @(negedge clk);
    chk(err_irq === 1'b0, "R9 irq one cycle", DW'(err_irq), 0);
    chk(resp_valid === 1'b0, "R2 drained", DW'(resp_valid), 0);
  endtask

  task automatic t_reset();
    chk(resp_valid === 1'b0, "R11 resp_valid", DW'(resp_valid), 0);
    chk(err_irq === 1'b0, "R11 irq", DW'(err_irq), 0);
    chk(stat_row === 4'd0, "R11 stat_row", DW'(stat_row), 0);
    chk(stat_bit === 16'd0, "R11 stat_bit", DW'(stat_bit), 0);
    chk(req_ready === 1'b1, "R11 req_ready", DW'(req_ready), 1);
  endtask

  task automatic t_clean();
    do_write(4'd3, pat(1));
    read_expect("R1 clean", 4'd3, pat(1), 0, 0);
    do_write(4'd4, '1);
    read_expect("R1 ones", 4'd4, '1, 0, 0);
  endtask

  task automatic t_single();
    rx_err_en = 1'b1;
    arm(4'd5, 0, 17, 0);
    do_write(4'd5, pat(2));
    read_expect("R3 single", 4'd5, pat(2), 1, 0);
    chk(stat_row === 4'd5, "R3 stat_row", DW'(stat_row), 5);
    chk(stat_bit === 16'd17, "R3 stat_bit", DW'(stat_bit), 17);
    arm(4'd2, 0, 207, 0);
    do_write(4'd2, pat(9));
    read_expect("R3 top bit", 4'd2, pat(9), 1, 0);
    chk(stat_bit === 16'd207, "R3 stat_bit 207", DW'(stat_bit), 207);
  endtask

  task automatic t_status_hold();
    read_expect("R12 clean read", 4'd3, pat(1), 0, 0);
    chk(stat_row === 4'd2, "R12 row held", DW'(stat_row), 2);
    chk(stat_bit === 16'd207, "R12 bit held", DW'(stat_bit), 207);
  endtask

  task automatic t_double();
    logic [DW-1:0] e;
    arm(4'd6, 1, 200, 205);
    do_write(4'd6, pat(3));
    e = pat(3);
    e[200] = ~e[200];
    e[205] = ~e[205];
    read_expect("R4 double", 4'd6, e, 0, 1);
    chk(stat_row === 4'd6, "R4 stat_row", DW'(stat_row), 6);
    chk(stat_bit === 16'd0, "R4 stat_bit", DW'(stat_bit), 0);
  endtask

  task automatic t_code_field();
    arm(4'd7, 0, 210, 0);
    do_write(4'd7, pat(4));
    read_expect("R5 check bit", 4'd7, pat(4), 1, 0);
    chk(stat_bit === 16'd0, "R5 idx zero", DW'(stat_bit), 0);
    arm(4'd7, 0, 216, 0);
    do_write(4'd7, pat(5));
    read_expect("R5 parity bit", 4'd7, pat(5), 1, 0);
    chk(stat_bit === 16'd0, "R5 idx zero parity", DW'(stat_bit), 0);
  endtask

  task automatic t_crc_mode();
    crc_mode = 1'b1;
    arm(4'd8, 0, 5, 0);
    do_write(4'd8, pat(6));
    crc_mode = 1'b0;
    read_expect("R6 suppressed", 4'd8, pat(6), 0, 0);
    do_write(4'd8, pat(7));
    read_expect("R6 consumed", 4'd8, pat(7), 0, 0);
  endtask

  task automatic t_enables();
    rx_err_en = 1'b0; tx_err_en = 1'b0;
    arm(4'd9, 0, 9, 0);
    do_write(4'd9, pat(8));
    read_expect("R7 no enable", 4'd9, pat(8), 0, 0);
    tx_err_en = 1'b1;
    arm(4'd9, 0, 9, 0);
    do_write(4'd9, pat(8));
    read_expect("R7 tx enable", 4'd9, pat(8), 1, 0);
    chk(stat_bit === 16'd9, "R7 stat_bit", DW'(stat_bit), 9);
  endtask

  task automatic t_row_once();
    arm(4'd10, 0, 3, 0);
    do_write(4'd11, pat(10));
    read_expect("R8 other row", 4'd11, pat(10), 0, 0);
    do_write(4'd10, pat(11));
    read_expect("R8 target row", 4'd10, pat(11), 1, 0);
    do_write(4'd10, pat(12));
    read_expect("R8 second write", 4'd10, pat(12), 0, 0);
  endtask

  task automatic t_upper();
    arm(4'd12, 0, 230, 0);
    do_write(4'd12, pat(13));
    read_expect("R10 upper bit", 4'd12, pat(13), 0, 0);
  endtask

  task automatic t_stall();
    resp_ready = 1'b0;
    start_read(4'd5);
    chk(resp_valid === 1'b1 && resp_sec === 1'b1, "R2 stalled valid", DW'(resp_sec), 1);
    chk(err_irq === 1'b1, "R9 irq on stall", DW'(err_irq), 1);
    chk(req_ready === 1'b0, "R2 ready low", DW'(req_ready), 0);
    @(negedge clk);
    chk(err_irq === 1'b0, "R9 single pulse", DW'(err_irq), 0);
    chk(resp_valid === 1'b1, "R2 still valid", DW'(resp_valid), 1);
    chk(resp_data === pat(2), "R2 data held", resp_data, pat(2));
    chk(req_ready === 1'b0, "R2 ready still low", DW'(req_ready), 0);
    resp_ready = 1'b1;
    @(negedge clk);
    chk(resp_valid === 1'b0, "R2 released", DW'(resp_valid), 0);
    chk(req_ready === 1'b1, "R2 ready back", DW'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single();
    t_status_hold();
    t_double();
    t_code_field();
    t_crc_mode();
    t_enables();
    t_row_once();
    t_upper();
    t_stall();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule